// File: doc/BRIEF.md
# Converter Chain Reset, Sync and Configuration Sequencer

This block runs on the host side of four daisy-chained sigma-delta converters. It takes them from power-up to a running, aligned and configured state. A single start pulse sets off a fixed sequence:

1. A shared active-low reset pulse goes out.
2. A shared active-low sync pulse follows. Both pulses open and close on falling edges of the converter master clock, which the host samples rather than generates.
3. One 32-bit register write (16 address bits, then 16 data bits) is shifted into the serial input at the head of the chain, framed by an active-low frame line. The block generates the serial clock for this write.

A done flag marks the end of the sequence.

A separate resync request replays only the sync pulse. This is the step needed after the decimation setting of the converters has been changed. The power-mode register sits at address 0x0001, and the same word must reach every converter. The register word is captured when the sequence starts, so the host may change its input afterwards.

Top module: `adc_chain_sequencer`

## Requirements
- R1: After system reset, converter reset, sync and frame lines are high, the serial clock is high, serial data is 0 and done is 0.
- R2: On start the converter reset line goes low in the third system-clock cycle after the next master-clock fall reaches the block. It stays low for exactly RST_EDGES master-clock periods and is released with the same three-cycle lag after a master-clock fall.
- R3: Sync goes low exactly one master-clock period after reset is released. It stays low for exactly SYNC_EDGES master-clock periods and is released three system-clock cycles after a master-clock fall. Sync is never low while reset is low.
- R4: In a start sequence the frame line goes low in the same cycle that sync returns high. It is never low while reset or sync is low.
- R5: While the frame line is low there are exactly 32 rising serial-clock edges. The data sampled on them is the captured word, bit 31 first (address bits 31..16, then data bits 15..0). Serial data changes only after a serial-clock fall and is stable while the serial clock is high.
- R6: Each serial-clock phase lasts SCLK_HALF system-clock cycles, counted from the frame fall. The frame line rises SCLK_HALF cycles after the 32nd rising edge. Outside a frame the serial clock stays high.
- R7: Done is a single-cycle pulse in the cycle the frame line rises, with all three converter control lines high.
- R8: A resync request in idle produces only the sync pulse, timed as in R3. Reset and frame do not move, and done pulses in the cycle sync is released.
- R9: Start and resync asserted in the same idle cycle run the full start sequence once. The resync is dropped.
- R10: Start, resync and register-word changes that arrive while a sequence runs are ignored. Exactly one done pulse results, and the frame carries the word present at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous system reset |
| mclk | input | 1 | Converter master clock, sampled by the block |
| start | input | 1 | Begin full reset/sync/write sequence (idle only) |
| resync | input | 1 | Replay only the sync pulse (idle only) |
| regWord | input | 32 | Register write word: address in 31..16, data in 15..0 |
| adcResetN | output | 1 | Shared active-low converter reset |
| adcSyncN | output | 1 | Shared active-low converter sync |
| frameN | output | 1 | Active-low write frame to the chain |
| sclk | output | 1 | Serial write clock, idles high |
| sdi | output | 1 | Serial write data into the chain head |
| done | output | 1 | One-cycle completion pulse |

## Verification
Start and resync can reach the block in the same idle cycle. A request can also arrive while a sequence is already running. The bench provokes both cases. It raises the two requests together and judges the result by edge counts: exactly one reset fall, one sync fall, one frame of 32 edges and a single done. During a running sequence it repeats both requests and swaps the register word, then watches a long quiet window for any second pulse. A sweep of the start moment over every system-clock phase of the master clock confirms that the three-cycle edge lag and the pulse widths hold whatever the phase.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RST_ARM,
    S_RST_LOW,
    S_SYNC_ARM,
    S_SYNC_LOW,
    S_FRAME
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic edgeClr;   // clear master-clock edge counter
    logic edgeInc;   // count one master-clock fall
    logic loadWord;  // capture register word into shifter
    logic serRun;    // serial write in progress
  } dpStrobe_t;

endpackage

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int SCLK_HALF = 2,
  parameter int CNT_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mclk,
  input  logic [WORD_W-1:0] regWord,
  input  dpStrobe_t         strb,
  output logic              mclkFall,
  output logic [CNT_W-1:0]  edgeCnt,
  output logic              frameEnd,
  output logic              sclk,
  output logic              sdi
);

  localparam int HALF_W = $clog2(SCLK_HALF) + 1;
  localparam int BIT_W  = $clog2(WORD_W + 1);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(SCLK_HALF - 1);
  localparam logic [BIT_W-1:0]  BIT_ALL   = BIT_W'(WORD_W);

  // master-clock sampling and falling-edge detection
  logic mclkMeta, mclkSync, mclkLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mclkMeta <= 1'b0;
      mclkSync <= 1'b0;
      mclkLast <= 1'b0;
    end else begin
      mclkMeta <= mclk;
      mclkSync <= mclkMeta;
      mclkLast <= mclkSync;
    end
  end

  assign mclkFall = mclkLast & ~mclkSync;

  // pulse-width counter in master-clock falls
  always_ff @(posedge clk) begin
    if (!rstN || strb.edgeClr) edgeCnt <= '0;
    else if (strb.edgeInc)     edgeCnt <= edgeCnt + 1'b1;
  end

  // serial clock generation
  logic [HALF_W-1:0] halfCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              sclkR;
  logic              tick;

  assign tick     = strb.serRun && (halfCnt == HALF_LAST);
  assign frameEnd = tick && sclkR && (bitCnt == BIT_ALL);

  always_ff @(posedge clk) begin
    if (!rstN || !strb.serRun) begin
      halfCnt <= '0;
      sclkR   <= 1'b1;
      bitCnt  <= '0;
    end else begin
      halfCnt <= tick ? '0 : halfCnt + 1'b1;
      if (tick) begin
        if (sclkR) begin
          if (bitCnt != BIT_ALL) sclkR <= 1'b0;
        end else begin
          sclkR  <= 1'b1;
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // write word shifter, MSB first, advances on serial-clock falls
  logic [WORD_W-1:0] shReg;

  always_ff @(posedge clk) begin
    if (!rstN)
      shReg <= '0;
    else if (strb.loadWord)
      shReg <= regWord;
    else if (tick && sclkR && bitCnt != '0 && bitCnt != BIT_ALL)
      shReg <= {shReg[WORD_W-2:0], 1'b0};
  end

  assign sclk = sclkR;
  assign sdi  = shReg[WORD_W-1];

endmodule

// File: rtl/adc_seq_control.sv
module adc_seq_control
  import adc_seq_pkg::*;
#(
  parameter int RST_EDGES  = 1,
  parameter int SYNC_EDGES = 4,
  parameter int CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             resync,
  input  logic             mclkFall,
  input  logic [CNT_W-1:0] edgeCnt,
  input  logic             frameEnd,
  output dpStrobe_t        strb,
  output logic             adcResetN,
  output logic             adcSyncN,
  output logic             frameN,
  output logic             done
);

  localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(RST_EDGES - 1);
  localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_EDGES - 1);

  seqState_e state, nxt;
  logic      fullSeq;
  logic      setFull, clrFull, goDone;

  always_comb begin
    nxt         = state;
    strb        = '0;
    strb.serRun = (state == S_FRAME);
    setFull     = 1'b0;
    clrFull     = 1'b0;
    goDone      = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          strb.loadWord = 1'b1;
          setFull       = 1'b1;
          nxt           = S_RST_ARM;
        end else if (resync) begin
          clrFull = 1'b1;
          nxt     = S_SYNC_ARM;
        end
      end
      S_RST_ARM: begin
        strb.edgeClr = 1'b1;
        if (mclkFall) nxt = S_RST_LOW;
      end
      S_RST_LOW: begin
        if (mclkFall) begin
          if (edgeCnt == RST_LAST) nxt = S_SYNC_ARM;
          else strb.edgeInc = 1'b1;
        end
      end
      S_SYNC_ARM: begin
        strb.edgeClr = 1'b1;
        if (mclkFall) nxt = S_SYNC_LOW;
      end
      S_SYNC_LOW: begin
        if (mclkFall) begin
          if (edgeCnt == SYNC_LAST) begin
            if (fullSeq) nxt = S_FRAME;
            else begin
              nxt    = S_IDLE;
              goDone = 1'b1;
            end
          end else begin
            strb.edgeInc = 1'b1;
          end
        end
      end
      S_FRAME: begin
        if (frameEnd) begin
          nxt    = S_IDLE;
          goDone = 1'b1;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      fullSeq <= 1'b0;
      done    <= 1'b0;
    end else begin
      state <= nxt;
      done  <= goDone;
      if (setFull)      fullSeq <= 1'b1;
      else if (clrFull) fullSeq <= 1'b0;
    end
  end

  assign adcResetN = (state != S_RST_LOW);
  assign adcSyncN  = (state != S_SYNC_LOW);
  assign frameN    = (state != S_FRAME);

endmodule

// File: rtl/adc_chain_sequencer.sv
module adc_chain_sequencer
  import adc_seq_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int RST_EDGES  = 1,
  parameter int SYNC_EDGES = 4,
  parameter int SCLK_HALF  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mclk,
  input  logic              start,
  input  logic              resync,
  input  logic [WORD_W-1:0] regWord,
  output logic              adcResetN,
  output logic              adcSyncN,
  output logic              frameN,
  output logic              sclk,
  output logic              sdi,
  output logic              done
);

  localparam int MAX_EDGES = (RST_EDGES > SYNC_EDGES) ? RST_EDGES : SYNC_EDGES;
  localparam int CNT_W     = $clog2(MAX_EDGES + 1);

  dpStrobe_t        strb;
  logic             mclkFall;
  logic [CNT_W-1:0] edgeCnt;
  logic             frameEnd;

  adc_seq_control #(
    .RST_EDGES (RST_EDGES),
    .SYNC_EDGES(SYNC_EDGES),
    .CNT_W     (CNT_W)
  ) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .resync   (resync),
    .mclkFall (mclkFall),
    .edgeCnt  (edgeCnt),
    .frameEnd (frameEnd),
    .strb     (strb),
    .adcResetN(adcResetN),
    .adcSyncN (adcSyncN),
    .frameN   (frameN),
    .done     (done)
  );

  adc_seq_datapath #(
    .WORD_W   (WORD_W),
    .SCLK_HALF(SCLK_HALF),
    .CNT_W    (CNT_W)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .mclk    (mclk),
    .regWord (regWord),
    .strb    (strb),
    .mclkFall(mclkFall),
    .edgeCnt (edgeCnt),
    .frameEnd(frameEnd),
    .sclk    (sclk),
    .sdi     (sdi)
  );

endmodule

// File: rtl/adc_chain_sequencer_checker.sv
module adc_chain_sequencer_checker (
  input logic clk,
  input logic rstN,
  input logic mclkFall,
  input logic adcResetN,
  input logic adcSyncN,
  input logic frameN,
  input logic sclk,
  input logic sdi,
  input logic done
);

  a_r2_reset_release_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcResetN) |-> $past(mclkFall));

  a_r3_sync_release_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcSyncN) |-> $past(mclkFall));

  a_r3_sync_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    !adcSyncN |-> adcResetN);

  a_r4_frame_isolated: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |-> (adcResetN && adcSyncN));

  a_r5_sdi_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (!frameN && $past(!frameN) && sclk && $past(sclk)) |-> $stable(sdi));

  a_r6_sclk_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    frameN |-> sclk);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_done_all_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (frameN && adcSyncN && adcResetN));

endmodule

bind adc_chain_sequencer adc_chain_sequencer_checker i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .mclkFall (mclkFall),
  .adcResetN(adcResetN),
  .adcSyncN (adcSyncN),
  .frameN   (frameN),
  .sclk     (sclk),
  .sdi      (sdi),
  .done     (done)
);

// File: tb/test_adc_chain_sequencer.sv
`timescale 1ns/1ps
module test_adc_chain_sequencer;

  localparam int MP    = 16;  // master-clock period in system cycles
  localparam int H     = 2;
  localparam int RSTE  = 1;
  localparam int SYNCE = 4;
  localparam int LAG   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mclk = 1'b1;
  logic start = 1'b0;
  logic resync = 1'b0;
  logic [31:0] regWord = '0;
  logic adcResetN, adcSyncN, frameN, sclk, sdi, done;

  always #2 clk = ~clk;

  adc_chain_sequencer #(
    .WORD_W(32), .RST_EDGES(RSTE), .SYNC_EDGES(SYNCE), .SCLK_HALF(H)
  ) i_adc_chain_sequencer (
    .clk(clk), .rstN(rstN), .mclk(mclk), .start(start), .resync(resync),
    .regWord(regWord), .adcResetN(adcResetN), .adcSyncN(adcSyncN),
    .frameN(frameN), .sclk(sclk), .sdi(sdi), .done(done)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor state
  int cyc = 0, sinceFall = 0, mcnt = 0;
  int rstLow, rstFallN, rstFallDelta, rstRiseDelta, rstRiseCyc;
  int syncLow, syncFallN, syncFallDelta, syncRiseDelta, syncFallCyc, syncRiseCyc;
  int frameFallN, frameFallCyc, frameRiseCyc, nRise, lastRiseCyc, lastChgCyc, sclkBad;
  int doneN, doneCyc, doneIdleBad;
  logic [31:0] bits;
  logic pRst = 1'b1, pSync = 1'b1, pFrame = 1'b1, pSclk = 1'b1;

  task automatic clrMon();
    rstLow = 0; rstFallN = 0; rstFallDelta = -1; rstRiseDelta = -1; rstRiseCyc = -1;
    syncLow = 0; syncFallN = 0; syncFallDelta = -1; syncRiseDelta = -1;
    syncFallCyc = -1; syncRiseCyc = -1;
    frameFallN = 0; frameFallCyc = -1; frameRiseCyc = -1; nRise = 0;
    lastRiseCyc = -1; lastChgCyc = 0; sclkBad = 0;
    doneN = 0; doneCyc = -1; doneIdleBad = 0; bits = '0;
  endtask

  always @(negedge clk) begin
    cyc++;
    sinceFall++;
    if (rstN) begin
      if (!adcResetN) rstLow++;
      if (pRst && !adcResetN) begin rstFallN++; rstFallDelta = sinceFall; end
      if (!pRst && adcResetN) begin rstRiseDelta = sinceFall; rstRiseCyc = cyc; end
      if (!adcSyncN) syncLow++;
      if (pSync && !adcSyncN) begin syncFallN++; syncFallDelta = sinceFall; syncFallCyc = cyc; end
      if (!pSync && adcSyncN) begin syncRiseDelta = sinceFall; syncRiseCyc = cyc; end
      if (pFrame && !frameN) begin frameFallN++; frameFallCyc = cyc; lastChgCyc = cyc; end
      if (!frameN && sclk != pSclk) begin
        if (cyc - lastChgCyc != H) sclkBad++;
        lastChgCyc = cyc;
        if (sclk) begin bits = {bits[30:0], sdi}; nRise++; lastRiseCyc = cyc; end
      end
      if (!pFrame && frameN) frameRiseCyc = cyc;
      if (done) begin
        doneN++; doneCyc = cyc;
        if (!(frameN && adcSyncN && adcResetN)) doneIdleBad++;
      end
    end
    pRst = adcResetN; pSync = adcSyncN; pFrame = frameN; pSclk = sclk;
    mcnt = (mcnt + 1) % MP;
    mclk = (mcnt < MP/2);
    if (mcnt == MP/2) sinceFall = 0;
  end

  task automatic printSummary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    printSummary();
    $finish;
  end

  task automatic waitDone();
    int t = 0;
    while (doneN == 0 && t < 3000) begin @(negedge clk); #1; t++; end
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic pulse(input logic s, input logic r);
    start = s; resync = r;
    @(negedge clk); #1;
    start = 1'b0; resync = 1'b0;
  endtask

  task automatic checkFull(input logic [31:0] w);
    chk(rstFallN == 1, "R2 reset fall count", rstFallN, 1);
    chk(rstFallDelta == LAG, "R2 reset fall lag", rstFallDelta, LAG);
    chk(rstLow == RSTE*MP, "R2 reset low width", rstLow, RSTE*MP);
    chk(rstRiseDelta == LAG, "R2 reset release lag", rstRiseDelta, LAG);
    chk(syncFallCyc - rstRiseCyc == MP, "R3 reset-to-sync gap", syncFallCyc - rstRiseCyc, MP);
    chk(syncLow == SYNCE*MP, "R3 sync low width", syncLow, SYNCE*MP);
    chk(syncRiseDelta == LAG, "R3 sync release lag", syncRiseDelta, LAG);
    chk(frameFallN == 1 && frameFallCyc == syncRiseCyc, "R4 frame start", frameFallCyc, syncRiseCyc);
    chk(nRise == 32, "R5 rising edge count", nRise, 32);
    chk(bits == w, "R5 shifted word", bits, w);
    chk(sclkBad == 0, "R6 serial clock phases", sclkBad, 0);
    chk(frameRiseCyc - lastRiseCyc == H, "R6 frame end delay", frameRiseCyc - lastRiseCyc, H);
    chk(doneN == 1 && doneCyc == frameRiseCyc, "R7 done pulse", doneCyc, frameRiseCyc);
    chk(doneIdleBad == 0, "R7 done with lines idle", doneIdleBad, 0);
  endtask

  initial begin
    clrMon();
    repeat (5) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(adcResetN && adcSyncN && frameN, "R1 control lines high", {adcResetN, adcSyncN, frameN}, 3'b111);
    chk(sclk == 1'b1 && sdi == 1'b0, "R1 serial idle", {sclk, sdi}, 2'b10);
    chk(done == 1'b0, "R1 done low", done, 0);
    repeat (2 * MP) @(negedge clk);

    // phase sweep of start against the master clock (R2..R7)
    for (int p = 0; p < MP; p++) begin
      logic [31:0] w;
      w = {16'h0001, 16'hA5C3 ^ 16'(p * 16'h1357)};
      if (p == 3) w = 32'hFFFF_FFFF;
      if (p == 7) w = 32'h8000_0001;
      do begin @(negedge clk); #1; end while (mcnt != p);
      clrMon();
      regWord = w;
      pulse(1'b1, 1'b0);
      regWord = ~w;
      waitDone();
      checkFull(w);
    end

    // R8 resync alone
    for (int p = 0; p < 4; p++) begin
      do begin @(negedge clk); #1; end while (mcnt != p * 4);
      clrMon();
      pulse(1'b0, 1'b1);
      waitDone();
      chk(rstFallN == 0, "R8 reset untouched", rstFallN, 0);
      chk(syncFallDelta == LAG && syncLow == SYNCE*MP, "R8 sync width", syncLow, SYNCE*MP);
      chk(syncRiseDelta == LAG, "R8 sync release lag", syncRiseDelta, LAG);
      chk(frameFallN == 0 && nRise == 0, "R8 no frame", frameFallN, 0);
      chk(doneN == 1 && doneCyc == syncRiseCyc, "R8 done at sync release", doneCyc, syncRiseCyc);
    end

    // R9 start and resync together
    clrMon();
    regWord = 32'h0001_3C5A;
    pulse(1'b1, 1'b1);
    waitDone();
    checkFull(32'h0001_3C5A);
    repeat (8 * MP) @(negedge clk);
    #1;
    chk(syncFallN == 1 && doneN == 1, "R9 single sequence", syncFallN, 1);

    // R10 requests and word changes while busy
    clrMon();
    regWord = 32'h0001_6E21;
    pulse(1'b1, 1'b0);
    regWord = 32'h1234_5678;
    repeat (MP + 5) @(negedge clk);
    #1 pulse(1'b1, 1'b0);
    repeat (2 * MP) @(negedge clk);
    #1 pulse(1'b0, 1'b1);
    wait (frameN == 1'b0);
    @(negedge clk); #1 pulse(1'b1, 1'b1);
    waitDone();
    chk(bits == 32'h0001_6E21, "R10 word captured at start", bits, 32'h0001_6E21);
    repeat (10 * MP) @(negedge clk);
    #1;
    chk(rstFallN == 1 && syncFallN == 1, "R10 no extra pulses", rstFallN + syncFallN, 2);
    chk(doneN == 1 && frameFallN == 1, "R10 single done", doneN, 1);

    printSummary();
    $finish;
  end

endmodule